// File: doc/BRIEF.md
# Outbound Frame Header Prepender

This block sits between a packet source and a bulk-transfer endpoint. It takes one outbound Ethernet frame at a time from a byte-wide valid/ready stream that marks the first and last beat of the frame. It stores the whole frame in an internal buffer. Once the last byte has arrived the length is known, and the block then sends two 32-bit control words ahead of the payload. The first word carries the length and two segment flags. The second word repeats the length. The endpoint therefore receives eight header bytes followed by the frame.

A frame longer than the configured maximum is never emitted. The block raises a one-cycle error pulse, absorbs the rest of that frame up to its end marker, and then waits for the next start marker. Only one frame is held at a time. The input is stalled while a stored frame is still being sent, and the output honours the consumer's ready signal on every byte.

Top module: `tx_cmd_framer`

## Requirements
- R1: While reset is held and in the cycle after it, `out_valid` and `oversize_err` are low and `in_ready` is high.
- R2: Output bytes 0..3 of a frame of N payload bytes form the 32-bit word N | (1<<13) | (1<<12), sent least significant byte first. Bit 13 is the first-segment flag and bit 12 is the last-segment flag. N occupies bits 11:0 and every other bit is zero.
- R3: Output bytes 4..7 form the 32-bit word N, zero-extended and sent least significant byte first.
- R4: The N payload bytes follow in arrival order, so a frame emits N+8 bytes. `out_sof` is high only on byte 0 and `out_eof` only on byte N+7.
- R5: While `out_valid` is high and `out_ready` is low, `out_data`, `out_sof` and `out_eof` hold their values and no byte is lost or repeated, whatever the ready pattern.
- R6: The smallest frame (1 byte, with start and end on the same beat) and a frame of exactly MAX_LEN bytes are both emitted correctly.
- R7: A frame that reaches MAX_LEN+1 bytes produces exactly one single-cycle `oversize_err` pulse, and none of its bytes or header bytes appear at the output.
- R8: After an oversize error the block keeps `in_ready` high and discards input up to the end marker. The next frame is then processed normally.
- R9: While a stored frame is being emitted, `in_ready` is low. Beats accepted without `in_sof` while no frame is open are dropped and produce no output.
- R10: A beat with `in_sof` that arrives while a frame is still being collected discards the partial frame and starts a new one at that beat.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Block can take an input beat |
| in_data | input | 8 | Input frame byte |
| in_sof | input | 1 | First byte of a frame |
| in_eof | input | 1 | Last byte of a frame |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Consumer takes the output byte |
| out_data | output | 8 | Header or payload byte |
| out_sof | output | 1 | First header byte |
| out_eof | output | 1 | Last payload byte |
| oversize_err | output | 1 | One-cycle pulse when a frame exceeds MAX_LEN |

## Verification
A wrong byte count in the collector shows up in the first header byte. That byte leaves the block a few cycles after the end marker, so the error appears at once in bytes 0 and 4 and again in the position of `out_eof`. A fault in the read prefetch or its valid flag shows up as payload bytes that are duplicated or shifted. This is exposed under toggling and pseudo-random ready patterns, not under a steady ready. A wrong state in the collector, such as failing to discard after an oversize frame or failing to restart on a new start marker, shows up as extra or missing bytes in the next frame emitted.

// File: rtl/tcf_pkg.sv
package tcf_pkg;

  localparam int FIRST_SEG_BIT = 13;
  localparam int LAST_SEG_BIT  = 12;
  localparam int HDR_BYTES     = 8;

  typedef enum logic [1:0] {
    ING_IDLE    = 2'd0,
    ING_CAPTURE = 2'd1,
    ING_DISCARD = 2'd2
  } ing_state_t;

  // Header byte sel (0..7): bytes 0-3 word A, 4-7 word B, LSB first
  function automatic logic [7:0] hdr_byte(input logic [2:0] sel, input logic [31:0] len);
    logic [31:0] w;
    w = sel[2] ? len
               : (len | (32'd1 << FIRST_SEG_BIT) | (32'd1 << LAST_SEG_BIT));
    return w[8*sel[1:0] +: 8];
  endfunction

endpackage

// File: rtl/tcf_frame_ram.sv
module tcf_frame_ram #(
  parameter int DW = 8,
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/tcf_ingress.sv
module tcf_ingress
  import tcf_pkg::*;
#(
  parameter int MAX_LEN = 2048,
  parameter int CNT_W   = 12,
  parameter int AW      = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             in_sof,
  input  logic             in_eof,
  output logic             in_ready,
  input  logic             eg_busy,
  output logic             wr_en,
  output logic [AW-1:0]    wr_addr,
  output logic             start,
  output logic [CNT_W-1:0] start_len,
  output logic             oversize_err
);
  ing_state_t       state;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] next_cnt;
  logic             acc;
  logic             take;
  logic             over;

  always_comb begin
    in_ready  = (state == ING_IDLE) ? !eg_busy : 1'b1;
    acc       = in_valid && in_ready;
    take      = acc && ((state == ING_CAPTURE) || (state == ING_IDLE && in_sof));
    next_cnt  = in_sof ? CNT_W'(1) : cnt + CNT_W'(1);
    over      = next_cnt > CNT_W'(MAX_LEN);
    wr_en     = take && !over;
    wr_addr   = AW'(next_cnt - CNT_W'(1));
    start     = take && !over && in_eof;
    start_len = next_cnt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ING_IDLE;
      cnt          <= '0;
      oversize_err <= 1'b0;
    end else begin
      oversize_err <= take && over;
      if (take) begin
        if (over) begin
          state <= in_eof ? ING_IDLE : ING_DISCARD;
        end else begin
          cnt   <= next_cnt;
          state <= in_eof ? ING_IDLE : ING_CAPTURE;
        end
      end else if (acc && state == ING_DISCARD && in_eof) begin
        state <= ING_IDLE;
      end
    end
  end

endmodule

// File: rtl/tcf_egress.sv
module tcf_egress
  import tcf_pkg::*;
#(
  parameter int CNT_W = 12,
  parameter int AW    = 11,
  parameter int IDX_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CNT_W-1:0] start_len,
  output logic             busy,
  output logic             rd_en,
  output logic [AW-1:0]    rd_addr,
  input  logic [7:0]       rd_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       out_data,
  output logic             out_sof,
  output logic             out_eof
);
  logic             active;
  logic [CNT_W-1:0] len_r;
  logic [CNT_W-1:0] fetch_cnt;
  logic [IDX_W-1:0] idx;
  logic [IDX_W-1:0] last_idx;
  logic             q_valid;
  logic             is_hdr;
  logic             load;
  logic             take_q;
  logic [7:0]       hdr_val;

  always_comb begin
    busy     = active;
    last_idx = IDX_W'(len_r) + IDX_W'(HDR_BYTES - 1);
    is_hdr   = idx < IDX_W'(HDR_BYTES);
    load     = active && (!out_valid || out_ready) && (is_hdr || q_valid);
    take_q   = load && !is_hdr;
    rd_en    = active && (fetch_cnt < len_r) && (!q_valid || take_q);
    rd_addr  = AW'(fetch_cnt);
    hdr_val  = hdr_byte(idx[2:0], 32'(len_r));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active    <= 1'b0;
      len_r     <= '0;
      fetch_cnt <= '0;
      idx       <= '0;
      q_valid   <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_sof   <= 1'b0;
      out_eof   <= 1'b0;
    end else begin
      if (!active && start) begin
        active    <= 1'b1;
        len_r     <= start_len;
        fetch_cnt <= '0;
        idx       <= '0;
        q_valid   <= 1'b0;
      end else begin
        if (rd_en) begin
          fetch_cnt <= fetch_cnt + CNT_W'(1);
          q_valid   <= 1'b1;
        end else if (take_q) begin
          q_valid   <= 1'b0;
        end
        if (load) begin
          idx <= idx + IDX_W'(1);
          if (idx == last_idx) active <= 1'b0;
        end
      end

      if (load) begin
        out_valid <= 1'b1;
        out_data  <= is_hdr ? hdr_val : rd_data;
        out_sof   <= (idx == '0);
        out_eof   <= (idx == last_idx);
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/tx_cmd_framer.sv
module tx_cmd_framer #(
  parameter int MAX_LEN = 2048
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  input  logic       in_sof,
  input  logic       in_eof,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_data,
  output logic       out_sof,
  output logic       out_eof,
  output logic       oversize_err
);
  localparam int CNT_W = $clog2(MAX_LEN + 2);
  localparam int AW    = $clog2(MAX_LEN);
  localparam int IDX_W = $clog2(MAX_LEN + 9);

  logic             eg_busy;
  logic             wr_en;
  logic [AW-1:0]    wr_addr;
  logic             start;
  logic [CNT_W-1:0] start_len;
  logic             rd_en;
  logic [AW-1:0]    rd_addr;
  logic [7:0]       rd_data;

  tcf_ingress #(.MAX_LEN(MAX_LEN), .CNT_W(CNT_W), .AW(AW)) ingress_i (
    .clk          (clk),
    .rst          (rst),
    .in_valid     (in_valid),
    .in_sof       (in_sof),
    .in_eof       (in_eof),
    .in_ready     (in_ready),
    .eg_busy      (eg_busy),
    .wr_en        (wr_en),
    .wr_addr      (wr_addr),
    .start        (start),
    .start_len    (start_len),
    .oversize_err (oversize_err)
  );

  tcf_frame_ram #(.DW(8), .AW(AW)) ram_i (
    .clk   (clk),
    .we    (wr_en),
    .waddr (wr_addr),
    .wdata (in_data),
    .re    (rd_en),
    .raddr (rd_addr),
    .rdata (rd_data)
  );

  tcf_egress #(.CNT_W(CNT_W), .AW(AW), .IDX_W(IDX_W)) egress_i (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .start_len (start_len),
    .busy      (eg_busy),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_sof   (out_sof),
    .out_eof   (out_eof)
  );

endmodule

// File: rtl/tx_cmd_framer_chk.sv
module tx_cmd_framer_chk (
  input logic       clk,
  input logic       rst,
  input logic       in_valid,
  input logic       in_ready,
  input logic [7:0] in_data,
  input logic       in_sof,
  input logic       in_eof,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data,
  input logic       out_sof,
  input logic       out_eof,
  input logic       oversize_err
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!out_valid && !oversize_err && in_ready));

  // R5
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_data) && $stable(out_sof) && $stable(out_eof)));

  // R7
  err_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    oversize_err |=> !oversize_err);

  // R7
  err_no_header_chk: assert property (@(posedge clk) disable iff (rst)
    oversize_err |-> !out_sof);

  // R4
  sof_not_eof_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_sof) |-> !out_eof);

  // R9
  busy_stall_in_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_eof) |-> !in_ready);

endmodule

bind tx_cmd_framer tx_cmd_framer_chk chk_i (.*);

// File: tb/tx_cmd_framer_tb_top.sv
module tx_cmd_framer_tb_top;
  localparam int MAX_LEN = 2048;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = '0;
  logic       in_sof = 1'b0;
  logic       in_eof = 1'b0;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [7:0] out_data;
  logic       out_sof;
  logic       out_eof;
  logic       oversize_err;

  int nchk = 0;
  int nerr = 0;
  int rdy_mode = 0;
  logic [15:0] lfsr = 16'hACE1;

  logic [7:0] pay   [0:4095];
  logic [7:0] cap_d [0:4095];
  logic       cap_s [0:4095];
  logic       cap_e [0:4095];
  int cap_n = 0;
  int err_seen = 0;

  tx_cmd_framer #(.MAX_LEN(MAX_LEN)) dut_i (.*);

  always #5 clk = ~clk;

  always begin
    @(posedge clk); #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    case (rdy_mode)
      0: out_ready = 1'b1;
      1: out_ready = ~out_ready;
      2: out_ready = lfsr[0] | lfsr[3];
      default: out_ready = 1'b0;
    endcase
  end

  always @(negedge clk) begin
    if (!rst) begin
      if (out_valid && out_ready && cap_n < 4096) begin
        cap_d[cap_n] = out_data;
        cap_s[cap_n] = out_sof;
        cap_e[cap_n] = out_eof;
        cap_n++;
      end
      if (oversize_err) err_seen++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic push_byte(input logic [7:0] d, input logic s, input logic e);
    in_valid = 1'b1; in_data = d; in_sof = s; in_eof = e;
    forever begin
      @(negedge clk);
      if (in_ready) break;
    end
    @(posedge clk); #1;
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
  endtask

  task automatic fill(input int n, input int seed);
    for (int i = 0; i < n; i++) pay[i] = 8'((i * 7 + seed) & 255);
  endtask

  task automatic send_frame(input int n);
    for (int i = 0; i < n; i++) push_byte(pay[i], i == 0, i == n - 1);
  endtask

  task automatic clear_cap();
    cap_n = 0; err_seen = 0;
  endtask

  task automatic wait_out(input int target);
    for (int k = 0; k < 20000 && cap_n < target; k++) begin
      @(posedge clk); #1;
    end
    repeat (12) @(posedge clk);
    #1;
  endtask

  task automatic verify_frame(input int n, input string req);
    logic [31:0] wa, wb;
    logic [7:0]  exp_b;
    int bad_a = 0, bad_b = 0, bad_p = 0, bad_f = 0;
    int fa = 0, fe = 0;
    wa = 32'(n) | (32'd1 << 13) | (32'd1 << 12);
    wb = 32'(n);
    chk(cap_n == n + 8, req, "R4 byte count", cap_n, n + 8);
    for (int i = 0; i < n + 8 && i < cap_n; i++) begin
      if (i < 4) exp_b = wa[8*i +: 8];
      else if (i < 8) exp_b = wb[8*(i-4) +: 8];
      else exp_b = pay[i-8];
      if (cap_d[i] !== exp_b) begin
        if (i < 4) bad_a++; else if (i < 8) bad_b++;
        else begin if (bad_p == 0) begin fa = cap_d[i]; fe = exp_b; end bad_p++; end
      end
      if (cap_s[i] !== (i == 0) || cap_e[i] !== (i == n + 7)) bad_f++;
    end
    chk(bad_a == 0, req, "R2 word A bytes wrong", bad_a, 0);
    chk(bad_b == 0, req, "R3 word B bytes wrong", bad_b, 0);
    chk(bad_p == 0, req, "R4 first bad payload byte", fa, fe);
    chk(bad_f == 0, req, "R4 sof/eof marker errors", bad_f, 0);
    chk(err_seen == 0, req, "no error pulse", err_seen, 0);
  endtask

  task automatic t_reset();
    chk(out_valid == 1'b0, "R1", "out_valid in reset", out_valid, 0);
    chk(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);
    chk(oversize_err == 1'b0, "R1", "err after reset", oversize_err, 0);
  endtask

  task automatic t_basic();
    clear_cap(); rdy_mode = 0; fill(60, 3);
    send_frame(60); wait_out(68);
    verify_frame(60, "R2_R3_R4 basic");
  endtask

  task automatic t_backpressure(input int mode);
    clear_cap(); rdy_mode = mode; fill(100, 11 + mode);
    send_frame(100); wait_out(108);
    verify_frame(100, "R5 backpressure");
    rdy_mode = 0;
  endtask

  task automatic t_min();
    clear_cap(); rdy_mode = 2; fill(1, 200);
    send_frame(1); wait_out(9);
    verify_frame(1, "R6 min");
    rdy_mode = 0;
  endtask

  task automatic t_max();
    clear_cap(); rdy_mode = 0; fill(MAX_LEN, 5);
    send_frame(MAX_LEN); wait_out(MAX_LEN + 8);
    verify_frame(MAX_LEN, "R6 max");
  endtask

  task automatic t_oversize(input int extra);
    clear_cap(); rdy_mode = 0; fill(MAX_LEN + 1 + extra, 9);
    send_frame(MAX_LEN + 1 + extra);
    repeat (30) @(posedge clk);
    #1;
    chk(err_seen == 1, "R7", "error pulses", err_seen, 1);
    chk(cap_n == 0, "R7", "bytes emitted for oversize", cap_n, 0);
    chk(in_ready == 1'b1, "R8", "in_ready after discard", in_ready, 1);
    clear_cap(); fill(20, 77);
    send_frame(20); wait_out(28);
    verify_frame(20, "R8 after oversize");
  endtask

  task automatic t_busy();
    clear_cap(); rdy_mode = 3; fill(10, 40);
    send_frame(10);
    repeat (20) @(posedge clk);
    @(negedge clk);
    chk(in_ready == 1'b0, "R9", "in_ready while emitting", in_ready, 0);
    chk(cap_n == 0, "R5", "bytes taken while ready low", cap_n, 0);
    @(posedge clk); #1;
    rdy_mode = 0;
    wait_out(18);
    verify_frame(10, "R5_R9 stalled");
  endtask

  task automatic t_stray();
    clear_cap(); rdy_mode = 0;
    push_byte(8'hEE, 1'b0, 1'b0);
    push_byte(8'hEF, 1'b0, 1'b1);
    repeat (10) @(posedge clk);
    #1;
    chk(cap_n == 0, "R9", "output from stray beats", cap_n, 0);
    fill(5, 90);
    send_frame(5); wait_out(13);
    verify_frame(5, "R9 stray");
  endtask

  task automatic t_restart();
    clear_cap(); rdy_mode = 0;
    push_byte(8'h11, 1'b1, 1'b0);
    push_byte(8'h22, 1'b0, 1'b0);
    push_byte(8'h33, 1'b0, 1'b0);
    fill(6, 123);
    send_frame(6); wait_out(14);
    verify_frame(6, "R10 restart");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(out_valid == 1'b0, "R1", "out_valid during reset", out_valid, 0);
    rst = 1'b0;
    @(posedge clk); #1;
    t_reset();
    t_basic();
    t_backpressure(1);
    t_backpressure(2);
    t_min();
    t_max();
    t_oversize(3);
    t_oversize(0);
    t_busy();
    t_stray();
    t_restart();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

endmodule